// File: doc/BRIEF.md
# Alarm Compare and Interrupt Flag Unit

This unit sits next to a real-time clock's timekeeping core. It holds a time-of-day alarm (seconds, minutes, hours, plus a day-of-month field) and checks that alarm against the live time each time the core finishes an update. It keeps three sticky event flags: one for the periodic tick, one for alarm match and one for update completion. It also keeps three enable bits, one per source. Any flag whose enable is set drives a level interrupt request.

Software reaches the unit through an index/data pair. A write with the index strobe loads the register pointer. Data reads and writes then act on the register that the pointer selects. Reading the flag register returns the flags and clears them. An event that lands in the same cycle as that read is kept.

Top module: `rtc_alarm_irq`

## Requirements
- R1: With `bus_sel_idx` high, a write loads the register pointer from the low bits of `bus_wdata`. With `bus_sel_idx` low, data accesses act on the pointed register. Pointer 0x01 is the seconds alarm, 0x03 the minutes alarm and 0x05 the hours alarm, each 8 bits wide and readable back. Pointer 0x0D holds a 5-bit day-of-month alarm in bits 4:0, and its bits 7:5 read as zero.
- R2: Pointer 0x0B is the enable register: bit 6 enables the periodic source, bit 5 the alarm source and bit 4 the update source. Its other bits read as zero.
- R3: An `upd_done` pulse sets the update flag, which is bit 4 of the flag register at pointer 0x0C, from the next cycle onward.
- R4: On an `upd_done` pulse, the alarm flag (bit 5 of 0x0C) is set when all of the following hold. Each of the seconds, minutes and hours alarm fields either equals the live value or holds 0xFF, which matches anything. The day-of-month alarm field either equals `now_mday` or is 0, which matches any day.
- R5: A `rate_tick` pulse sets the periodic flag, which is bit 6 of 0x0C.
- R6: Flags are set whatever the state of their enable bits.
- R7: Bit 7 of 0x0C and the `irq` output are high exactly when some flag is set together with its enable. `irq` is a level that stays high until the flag register is read.
- R8: A data read of pointer 0x0C returns the flags in that cycle and clears all of them at the following edge.
- R9: An event arriving in the same cycle as a read of 0x0C is not lost: its flag is set after the clear.
- R10: Pointers that map to no register read as zero, and writes to them change nothing.
- R11: After reset, every alarm field, the enable bits and the flags are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_idx | input | 1 | High: the access targets the pointer; low: the pointed register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clear-on-read side effect) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the pointed register (combinational) |
| now_sec | input | DATA_W | Live seconds from the timekeeping core |
| now_min | input | DATA_W | Live minutes |
| now_hour | input | DATA_W | Live hours |
| now_mday | input | MDAY_W | Live day of month |
| upd_done | input | 1 | One-cycle strobe: the time update has completed |
| rate_tick | input | 1 | One-cycle periodic tick |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with its defaults: 8-bit data, a 7-bit pointer and a 5-bit day field. The full 128-entry pointer space is therefore reachable, and the bench can probe unmapped entries as well as the mapped ones. With 8-bit fields, the 0xFF wildcard can sit next to live values that do and do not match, so every combination of wildcard fields can be exercised. The bench's reference model follows the same events clock by clock. This lets it stage an update pulse and a flag read in one cycle and then confirm that the flag reappears.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;
  localparam int PTR_ASEC  = 1;
  localparam int PTR_AMIN  = 3;
  localparam int PTR_AHOUR = 5;
  localparam int PTR_CTRL  = 11;
  localparam int PTR_FLAGS = 12;
  localparam int PTR_AMDAY = 13;
  // bit positions shared by enable and flag registers
  localparam int POS_UPD  = 4;
  localparam int POS_ALM  = 5;
  localparam int POS_PER  = 6;
  localparam int POS_SUM  = 7;
  // internal source order: [2]=periodic [1]=alarm [0]=update
  localparam int NSRC = 3;
endpackage

// File: rtl/rtc_alarm_regs.sv
`timescale 1ns/1ps
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 7,
  parameter int MDAY_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_idx,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  ptr,
  output logic [DATA_W-1:0] alm_sec,
  output logic [DATA_W-1:0] alm_min,
  output logic [DATA_W-1:0] alm_hour,
  output logic [MDAY_W-1:0] alm_mday,
  output logic [NSRC-1:0]   en
);
  logic wr_data;
  assign wr_data = wr && !sel_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      alm_sec  <= '0;
      alm_min  <= '0;
      alm_hour <= '0;
      alm_mday <= '0;
      en       <= '0;
    end else if (wr && sel_idx) begin
      ptr <= wdata[IDX_W-1:0];
    end else if (wr_data) begin
      if (ptr == IDX_W'(PTR_ASEC))  alm_sec  <= wdata;
      if (ptr == IDX_W'(PTR_AMIN))  alm_min  <= wdata;
      if (ptr == IDX_W'(PTR_AHOUR)) alm_hour <= wdata;
      if (ptr == IDX_W'(PTR_AMDAY)) alm_mday <= wdata[MDAY_W-1:0];
      if (ptr == IDX_W'(PTR_CTRL))  en <= {wdata[POS_PER], wdata[POS_ALM], wdata[POS_UPD]};
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match #(
  parameter int DATA_W = 8,
  parameter int MDAY_W = 5
) (
  input  logic [2:0][DATA_W-1:0] alm_hms,
  input  logic [2:0][DATA_W-1:0] now_hms,
  input  logic [MDAY_W-1:0]      alm_mday,
  input  logic [MDAY_W-1:0]      now_mday,
  output logic                   hit
);
  localparam logic [DATA_W-1:0] WILD = '1;

  function automatic logic field_hit(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] n);
    return (a == WILD) || (a == n);
  endfunction

  function automatic logic day_hit(input logic [MDAY_W-1:0] a, input logic [MDAY_W-1:0] n);
    return (a == '0) || (a == n);
  endfunction

  logic [2:0] f_hit;
  for (genvar g = 0; g < 3; g++) begin : g_field
    assign f_hit[g] = field_hit(alm_hms[g], now_hms[g]);
  end

  assign hit = (&f_hit) && day_hit(alm_mday, now_mday);
endmodule

// File: rtl/rtc_irq_flags.sv
`timescale 1ns/1ps
module rtc_irq_flags
  import rtc_alarm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic            clr,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flags,
  output logic            req
);
  logic [NSRC-1:0] kept;
  assign kept = clr ? '0 : flags;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= kept | ev;
  end

  assign req = |(flags & en);

  p_upd_sets_r3: assert property (@(posedge clk) disable iff (!rst_n) ev[0] |=> flags[0]);
  p_alarm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n) ev[1] |=> flags[1]);
  p_tick_sets_r5: assert property (@(posedge clk) disable iff (!rst_n) ev[2] |=> flags[2]);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(ev[1]));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev == '0) |=> flags == '0);
  p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev[0]) |=> flags[0]);
  p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !clr) |=> (flags & $past(en)) != '0);
endmodule

// File: rtl/rtc_alarm_irq.sv
`timescale 1ns/1ps
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 7,
  parameter int MDAY_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_idx,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] now_sec,
  input  logic [DATA_W-1:0] now_min,
  input  logic [DATA_W-1:0] now_hour,
  input  logic [MDAY_W-1:0] now_mday,
  input  logic              upd_done,
  input  logic              rate_tick,
  output logic              irq
);
  logic [IDX_W-1:0]  ptr;
  logic [DATA_W-1:0] alm_sec, alm_min, alm_hour;
  logic [MDAY_W-1:0] alm_mday;
  logic [NSRC-1:0]   en, flags, ev;
  logic              alarm_hit, flag_read, req;

  rtc_alarm_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .MDAY_W(MDAY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel_idx(bus_sel_idx), .wr(bus_wr), .wdata(bus_wdata),
    .ptr(ptr), .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
    .alm_mday(alm_mday), .en(en)
  );

  rtc_alarm_match #(.DATA_W(DATA_W), .MDAY_W(MDAY_W)) u_match (
    .alm_hms({alm_hour, alm_min, alm_sec}),
    .now_hms({now_hour, now_min, now_sec}),
    .alm_mday(alm_mday), .now_mday(now_mday), .hit(alarm_hit)
  );

  assign flag_read = bus_rd && !bus_sel_idx && (ptr == IDX_W'(PTR_FLAGS));
  assign ev = {rate_tick, upd_done && alarm_hit, upd_done};

  rtc_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(flag_read), .en(en),
    .flags(flags), .req(req)
  );

  assign irq = req;

  always_comb begin
    bus_rdata = '0;
    if (ptr == IDX_W'(PTR_ASEC))  bus_rdata = alm_sec;
    if (ptr == IDX_W'(PTR_AMIN))  bus_rdata = alm_min;
    if (ptr == IDX_W'(PTR_AHOUR)) bus_rdata = alm_hour;
    if (ptr == IDX_W'(PTR_AMDAY)) bus_rdata[MDAY_W-1:0] = alm_mday;
    if (ptr == IDX_W'(PTR_CTRL)) begin
      bus_rdata[POS_PER] = en[2];
      bus_rdata[POS_ALM] = en[1];
      bus_rdata[POS_UPD] = en[0];
    end
    if (ptr == IDX_W'(PTR_FLAGS)) begin
      bus_rdata[POS_SUM] = req;
      bus_rdata[POS_PER] = flags[2];
      bus_rdata[POS_ALM] = flags[1];
      bus_rdata[POS_UPD] = flags[0];
    end
  end

  p_alarm_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && alarm_hit) |=> flags[1]);
  p_irq_off_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_read && !upd_done && !rate_tick) |=> !irq);
endmodule

// File: tb/test_rtc_alarm_irq.sv
`timescale 1ns/1ps
module test_rtc_alarm_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel_idx = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0;
  logic [4:0] now_mday = '0;
  logic       upd_done = 1'b0, rate_tick = 1'b0;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_irq i_rtc_alarm_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel_idx(bus_sel_idx), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_mday(now_mday), .upd_done(upd_done), .rate_tick(rate_tick),
    .irq(irq)
  );

  // behavioural reference model
  int m_ptr, m_as, m_am, m_ah, m_ad, m_en, m_fl; // m_en/m_fl hold bits 6:4 as register values

  function automatic int m_irq();
    return ((m_fl & m_en) != 0) ? 1 : 0;
  endfunction

  function automatic int m_read();
    case (m_ptr)
      1: return m_as;
      3: return m_am;
      5: return m_ah;
      11: return m_en;
      12: return m_fl | (m_irq() << 7);
      13: return m_ad;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_as = 0; m_am = 0; m_ah = 0; m_ad = 0; m_en = 0; m_fl = 0;
    end else begin
      int evs;
      bit hit;
      hit = (m_as == 255 || m_as == now_sec) && (m_am == 255 || m_am == now_min) &&
            (m_ah == 255 || m_ah == now_hour) && (m_ad == 0 || m_ad == now_mday);
      evs = (rate_tick ? 64 : 0) | (upd_done ? 16 : 0) | ((upd_done && hit) ? 32 : 0);
      if (bus_rd && !bus_sel_idx && m_ptr == 12) m_fl = 0;
      m_fl = m_fl | evs;
      if (bus_wr && bus_sel_idx) m_ptr = bus_wdata % 128;
      else if (bus_wr) begin
        case (m_ptr)
          1: m_as = bus_wdata;
          3: m_am = bus_wdata;
          5: m_ah = bus_wdata;
          11: m_en = bus_wdata & 8'h70;
          13: m_ad = bus_wdata & 8'h1F;
          default: ;
        endcase
      end
    end
  end

  // every-clock comparison of the interrupt line (R7)
  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (irq !== m_irq()[0]) begin
      errors++;
      $display("FAIL R7 irq actual=%0b expected=%0d at %0t", irq, m_irq(), $time);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    bus_sel_idx = 0; bus_wr = 0; bus_rd = 0; upd_done = 0; rate_tick = 0;
  endtask

  task automatic set_ptr(input int a);
    cyc(); idle(); bus_sel_idx = 1; bus_wr = 1; bus_wdata = 8'(a);
  endtask

  task automatic wr_reg(input int a, input int v);
    set_ptr(a);
    cyc(); idle(); bus_wr = 1; bus_wdata = 8'(v);
    cyc(); idle();
  endtask

  task automatic rd_reg(input int a, input int with_upd, input string req);
    set_ptr(a);
    cyc(); idle(); bus_rd = 1; upd_done = (with_upd != 0);
    #1;
    checks++;
    if (bus_rdata !== 8'(m_read())) begin
      errors++;
      $display("FAIL %s read ptr=%0d actual=%02h expected=%02h", req, a, bus_rdata, m_read());
    end
    cyc(); idle();
  endtask

  task automatic update(input int s, input int m, input int h, input int d);
    cyc(); idle();
    now_sec = 8'(s); now_min = 8'(m); now_hour = 8'(h); now_mday = 5'(d); upd_done = 1;
    cyc(); idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    // R11 reset state
    rd_reg(1, 0, "R11"); rd_reg(3, 0, "R11"); rd_reg(5, 0, "R11");
    rd_reg(11, 0, "R11"); rd_reg(12, 0, "R11"); rd_reg(13, 0, "R11");
    // R1 alarm storage
    wr_reg(1, 8'h10); wr_reg(3, 8'h20); wr_reg(5, 8'h08); wr_reg(13, 8'hEF);
    rd_reg(1, 0, "R1"); rd_reg(3, 0, "R1"); rd_reg(5, 0, "R1"); rd_reg(13, 0, "R1");
    // R2 enables
    wr_reg(11, 8'hFF); rd_reg(11, 0, "R2"); wr_reg(11, 0); rd_reg(11, 0, "R2");
    // R3 update flag, R6 without enable, R8 clear
    update(8'h11, 8'h20, 8'h08, 15);
    rd_reg(12, 0, "R3"); rd_reg(12, 0, "R8");
    // R4 full match
    update(8'h10, 8'h20, 8'h08, 15);
    rd_reg(12, 0, "R4");
    // R4 wildcards
    wr_reg(1, 8'hFF); wr_reg(13, 0);
    update(8'h33, 8'h20, 8'h08, 3);
    rd_reg(12, 0, "R4");
    wr_reg(3, 8'hFF); wr_reg(5, 8'hFF);
    update(8'h01, 8'h59, 8'h17, 30);
    rd_reg(12, 0, "R4");
    // R4 mismatch on hour and on day
    wr_reg(5, 8'h09);
    update(8'h01, 8'h02, 8'h08, 4);
    rd_reg(12, 0, "R4");
    wr_reg(5, 8'hFF); wr_reg(13, 7);
    update(8'h01, 8'h02, 8'h08, 6);
    rd_reg(12, 0, "R4");
    // R5 periodic tick
    cyc(); idle(); rate_tick = 1; cyc(); idle();
    rd_reg(12, 0, "R5");
    // R7 enable alarm only
    wr_reg(11, 8'h20);
    update(1, 2, 3, 6);
    rd_reg(12, 0, "R7");
    update(1, 2, 3, 7);
    repeat (5) cyc();
    rd_reg(12, 0, "R7");
    rd_reg(12, 0, "R7");
    // R9 event during read
    wr_reg(11, 8'h70);
    cyc(); idle(); rate_tick = 1; cyc(); idle();
    rd_reg(12, 1, "R9");
    rd_reg(12, 0, "R9");
    rd_reg(12, 0, "R9");
    // R10 unmapped
    wr_reg(8'h20, 8'h55); rd_reg(8'h20, 0, "R10"); rd_reg(0, 0, "R10");
    wr_reg(8'h0E, 8'hAA); rd_reg(8'h0E, 0, "R10");
    rd_reg(1, 0, "R10"); rd_reg(11, 0, "R10"); rd_reg(13, 0, "R10");
    repeat (3) cyc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule